// File: doc/BRIEF.md
# Issue-Queue Sequence Tracker with Squash Walk and Held Instructions

This block keeps the bookkeeping side of an instruction issue queue, where every entry is known by its sequence number. It counts the free slots. It frees an entry when the issue stage reports that sequence number as issued. It refuses an insert when no slot is free. Picking which instruction to issue and waking up operands are handled elsewhere; this block only records, for each entry, which source operands were still outstanding when the entry arrived.

A squash request carries a sequence number. While that number is nonzero, a walk runs from the youngest entry toward older ones. In each cycle it marks up to `WALK` entries as squashed. Each marked entry is presented on a push lane together with the set of operand waits that are dropped for it. An entry that is not younger than the squash number ends the walk. Issued entries are already gone, and entries marked squashed earlier are not marked again. Squashed entries keep their slot until the issue stage drains them.

An instruction that must not run speculatively is inserted as held. It records no operand waits and waits until a release that names its sequence number. The release then forwards that sequence number to readiness checking. A release that finds no held entry with that sequence number is reported as a miss.

Top module: `iq_seq_tracker`

## Requirements
- R1: After reset, free_cnt equals DEPTH, full is 0, sq_busy is 0, all push_vld lanes are 0, and ins_err, rel_vld and rel_miss are 0.
- R2: An accepted insert lowers free_cnt by one. An issue notice whose sequence number matches a live entry raises it by one. An issue notice for an unknown sequence number leaves it unchanged. Each change is visible one cycle after the request.
- R3: full is 1 exactly when free_cnt is 0. An insert presented while full is dropped, free_cnt stays 0, and ins_err is 1 for the following cycle only.
- R4: During a squash with number S, every live, unsquashed entry whose sequence number is greater than S appears on a push lane exactly once. Entries with a sequence number of S or less are never pushed.
- R5: Up to WALK entries are pushed per cycle, youngest first. Lane 0 carries the largest sequence number, and a higher lane is valid only when every lower lane is valid.
- R6: push_drop for a lane (bit j of lane k at position k*SRC_N+j) equals the inverse of the ready bits that the entry's sources had at insert. For a held entry it is all zero.
- R7: A squash number of zero means no squash is active. A squash request carrying 0 starts nothing. sq_stop clears the active number and wins over a simultaneous request. sq_busy is 1 only while unpushed entries younger than the active number remain.
- R8: A held entry is forwarded only when released. A release naming its sequence number gives rel_vld=1 with rel_out_seq equal to that number in the next cycle.
- R9: A release naming a sequence number that is not a held, unreleased, unsquashed entry produces rel_miss=1 in the next cycle and no rel_vld. This covers an unknown number, a repeated release, and a held entry that has been squashed.
- R10: Squashing does not change free_cnt. A squashed entry keeps its slot until an issue notice for its sequence number frees it.
- R11: An entry squashed once is not pushed again by a later squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_hold | input | 1 | Insert as held (waits for release) |
| ins_src_rdy | input | SRC_N | Ready bit for each source operand at insert |
| iss_vld | input | 1 | Issue notice |
| iss_seq | input | SEQ_W | Sequence number that was issued |
| sq_req | input | 1 | Start a squash |
| sq_seq | input | SEQ_W | Squash sequence number (entries above it are squashed) |
| sq_stop | input | 1 | End the squash (clears the active number) |
| rel_req | input | 1 | Release request for a held entry |
| rel_seq | input | SEQ_W | Sequence number to release |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot |
| ins_err | output | 1 | Previous cycle's insert was rejected as full |
| sq_busy | output | 1 | Squash walk still has entries to push |
| push_vld | output | WALK | Push lane valid bits |
| push_seq | output | WALK*SEQ_W | Sequence number per push lane |
| push_drop | output | WALK*SRC_N | Operand waits dropped per push lane |
| rel_vld | output | 1 | A held entry was released |
| rel_out_seq | output | SEQ_W | Sequence number of the released entry |
| rel_miss | output | 1 | Previous cycle's release matched nothing |

## Verification
The assertions assume that sequence numbers are unique among live entries, that inserts arrive in increasing order, and that the numbers never wrap within a run. They also assume that no insert arrives while a squash is active, and that no issue or release names an entry in the same cycle the walk pushes it. The directed stimulus keeps to these rules. Each scenario uses a fresh range of sequence numbers. The squash is stopped before the next insert. Issues and releases are sent only after the walk has gone idle.

// File: rtl/iq_seq_pkg.sv
package iq_seq_pkg;

  typedef enum logic [1:0] {
    REL_IDLE = 2'd0,
    REL_HIT  = 2'd1,
    REL_MISS = 2'd2
  } rel_res_e;

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/iq_free_counter.sv
module iq_free_counter #(
  parameter int DEPTH = 8,
  localparam int CNT_W = iq_seq_pkg::cnt_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic             iss_hit,
  output logic             ins_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             err_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             err_d;
  logic             cnt_en;

  always_comb begin
    ins_ok = ins_vld && (cnt_q != '0);
    err_d  = ins_vld && (cnt_q == '0);
    cnt_en = ins_ok ^ iss_hit;
    cnt_d  = cnt_q;
    if (ins_ok && !iss_hit) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (!ins_ok && iss_hit) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(DEPTH);
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/iq_slot_pick.sv
module iq_slot_pick #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] busy_slots,
  output logic [DEPTH-1:0] pick_oh
);

  always_comb begin
    logic found;
    found   = 1'b0;
    pick_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !busy_slots[i]) begin
        pick_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/iq_squash_select.sv
module iq_squash_select #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int WALK  = 2
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
  output logic [WALK-1:0]             lane_vld,
  output logic [WALK-1:0][DEPTH-1:0]  lane_oh,
  output logic [WALK-1:0][SEQ_W-1:0]  lane_seq
);

  // Each lane takes the youngest remaining candidate, then masks it out.
  always_comb begin
    logic [DEPTH-1:0] remain;
    logic [DEPTH-1:0] oh;
    logic [SEQ_W-1:0] best;
    logic             any;
    remain   = cand;
    lane_vld = '0;
    lane_oh  = '0;
    lane_seq = '0;
    for (int k = 0; k < WALK; k++) begin
      oh   = '0;
      best = '0;
      any  = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (remain[i] && (!any || (seqs[i] > best))) begin
          oh    = '0;
          oh[i] = 1'b1;
          best  = seqs[i];
          any   = 1'b1;
        end
      end
      lane_vld[k] = any;
      lane_oh[k]  = oh;
      lane_seq[k] = best;
      remain      = remain & ~oh;
    end
  end

endmodule

// File: rtl/iq_release_lookup.sv
module iq_release_lookup #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input  logic [DEPTH-1:0]            held_open,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
  input  logic                        req,
  input  logic [SEQ_W-1:0]            req_seq,
  output logic [DEPTH-1:0]            hit_oh
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_oh[i] = req && held_open[i] && (seqs[i] == req_seq);
  end

endmodule

// File: rtl/iq_seq_tracker.sv
module iq_seq_tracker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int SRC_N = 2,
  parameter int WALK  = 2,
  localparam int CNT_W = iq_seq_pkg::cnt_width(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_vld,
  input  logic [SEQ_W-1:0]        ins_seq,
  input  logic                    ins_hold,
  input  logic [SRC_N-1:0]        ins_src_rdy,
  input  logic                    iss_vld,
  input  logic [SEQ_W-1:0]        iss_seq,
  input  logic                    sq_req,
  input  logic [SEQ_W-1:0]        sq_seq,
  input  logic                    sq_stop,
  input  logic                    rel_req,
  input  logic [SEQ_W-1:0]        rel_seq,
  output logic [CNT_W-1:0]        free_cnt,
  output logic                    full,
  output logic                    ins_err,
  output logic                    sq_busy,
  output logic [WALK-1:0]         push_vld,
  output logic [WALK*SEQ_W-1:0]   push_seq,
  output logic [WALK*SRC_N-1:0]   push_drop,
  output logic                    rel_vld,
  output logic [SEQ_W-1:0]        rel_out_seq,
  output logic                    rel_miss
);

  import iq_seq_pkg::*;

  // Entry state
  logic [DEPTH-1:0]            vld_q,  vld_d;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q,  seq_d;
  logic [DEPTH-1:0]            hold_q, hold_d;
  logic [DEPTH-1:0]            rls_q,  rls_d;
  logic [DEPTH-1:0]            sqd_q,  sqd_d;
  logic [DEPTH-1:0][SRC_N-1:0] wait_q, wait_d;
  logic                        ent_en;

  // Squash number and release result
  logic [SEQ_W-1:0] sqn_q, sqn_d;
  logic             sqn_en;
  rel_res_e         rres_q, rres_d;
  logic [SEQ_W-1:0] rseq_q, rseq_d;

  // Helpers
  logic             ins_ok;
  logic [DEPTH-1:0] alloc_oh;
  logic [DEPTH-1:0] iss_oh;
  logic             iss_hit;
  logic [DEPTH-1:0] cand;
  logic [DEPTH-1:0] walk_mask;
  logic [DEPTH-1:0] held_open;
  logic [DEPTH-1:0] rel_oh;
  logic [DEPTH-1:0] rel_eff;

  logic [WALK-1:0]            lane_vld;
  logic [WALK-1:0][DEPTH-1:0] lane_oh;
  logic [WALK-1:0][SEQ_W-1:0] lane_seq;

  // Issue match
  for (genvar i = 0; i < DEPTH; i++) begin : g_iss
    assign iss_oh[i] = iss_vld && vld_q[i] && (seq_q[i] == iss_seq);
  end
  assign iss_hit = |iss_oh;

  iq_free_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_vld (ins_vld),
    .iss_hit (iss_hit),
    .ins_ok  (ins_ok),
    .cnt_q   (free_cnt),
    .err_q   (ins_err)
  );

  iq_slot_pick #(.DEPTH(DEPTH)) u_pick (
    .busy_slots (vld_q),
    .pick_oh    (alloc_oh)
  );

  // Squash candidates: live, not yet squashed, younger than active number.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cand
    assign cand[i] = (sqn_q != '0) && vld_q[i] && !sqd_q[i] && (seq_q[i] > sqn_q);
  end

  iq_squash_select #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .WALK(WALK)) u_sel (
    .cand     (cand),
    .seqs     (seq_q),
    .lane_vld (lane_vld),
    .lane_oh  (lane_oh),
    .lane_seq (lane_seq)
  );

  always_comb begin
    walk_mask = '0;
    for (int k = 0; k < WALK; k++) begin
      walk_mask = walk_mask | lane_oh[k];
    end
  end

  assign held_open = vld_q & hold_q & ~rls_q & ~sqd_q;

  iq_release_lookup #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_rel (
    .held_open (held_open),
    .seqs      (seq_q),
    .req       (rel_req),
    .req_seq   (rel_seq),
    .hit_oh    (rel_oh)
  );

  // A release that collides with the walk pushing the same entry loses.
  assign rel_eff = rel_oh & ~walk_mask;

  // Push lane outputs
  for (genvar k = 0; k < WALK; k++) begin : g_lane
    logic [SRC_N-1:0] drop_k;
    always_comb begin
      drop_k = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (lane_oh[k][i]) begin
          drop_k = drop_k | wait_q[i];
        end
      end
    end
    assign push_vld[k]                   = lane_vld[k];
    assign push_seq[k*SEQ_W +: SEQ_W]    = lane_seq[k];
    assign push_drop[k*SRC_N +: SRC_N]   = drop_k;
  end

  assign sq_busy     = |cand;
  assign full        = (free_cnt == '0);
  assign rel_vld     = (rres_q == REL_HIT);
  assign rel_miss    = (rres_q == REL_MISS);
  assign rel_out_seq = rseq_q;

  // Entry next state
  always_comb begin
    vld_d  = vld_q;
    seq_d  = seq_q;
    hold_d = hold_q;
    rls_d  = rls_q;
    sqd_d  = sqd_q;
    wait_d = wait_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (iss_oh[i]) begin
        vld_d[i] = 1'b0;
      end
      if (walk_mask[i]) begin
        sqd_d[i]  = 1'b1;
        hold_d[i] = 1'b0;
        wait_d[i] = '0;
      end
      if (rel_eff[i]) begin
        rls_d[i] = 1'b1;
      end
      if (ins_ok && alloc_oh[i]) begin
        vld_d[i]  = 1'b1;
        seq_d[i]  = ins_seq;
        hold_d[i] = ins_hold;
        rls_d[i]  = 1'b0;
        sqd_d[i]  = 1'b0;
        wait_d[i] = ins_hold ? '0 : ~ins_src_rdy;
      end
    end
    ent_en = ins_ok || iss_hit || (|walk_mask) || (|rel_eff);
  end

  // Squash number and release result next state
  always_comb begin
    sqn_d  = sqn_q;
    sqn_en = sq_stop || sq_req;
    if (sq_stop) begin
      sqn_d = '0;
    end else if (sq_req) begin
      sqn_d = sq_seq;
    end
    rseq_d = rseq_q;
    rres_d = REL_IDLE;
    if (rel_req) begin
      rseq_d = rel_seq;
      rres_d = (|rel_eff) ? REL_HIT : REL_MISS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      seq_q  <= '0;
      hold_q <= '0;
      rls_q  <= '0;
      sqd_q  <= '0;
      wait_q <= '0;
      sqn_q  <= '0;
      rres_q <= REL_IDLE;
      rseq_q <= '0;
    end else begin
      if (ent_en) begin
        vld_q  <= vld_d;
        seq_q  <= seq_d;
        hold_q <= hold_d;
        rls_q  <= rls_d;
        sqd_q  <= sqd_d;
        wait_q <= wait_d;
      end
      if (sqn_en) begin
        sqn_q <= sqn_d;
      end
      rres_q <= rres_d;
      if (rel_req) begin
        rseq_q <= rseq_d;
      end
    end
  end

endmodule

// File: rtl/iq_seq_tracker_chk.sv
module iq_seq_tracker_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int SRC_N = 2,
  parameter int WALK  = 2,
  localparam int CNT_W = iq_seq_pkg::cnt_width(DEPTH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ins_vld,
  input logic                  rel_req,
  input logic [CNT_W-1:0]      free_cnt,
  input logic                  full,
  input logic                  ins_err,
  input logic                  sq_busy,
  input logic [WALK-1:0]       push_vld,
  input logic [WALK*SEQ_W-1:0] push_seq,
  input logic                  rel_vld,
  input logic                  rel_miss,
  input logic [DEPTH-1:0]      vld_q
);

  // R2: counter agrees with occupied slots
  a_r2_cnt_tracks_slots: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt == (CNT_W'(DEPTH) - CNT_W'($countones(vld_q))));

  // R2: counter moves by at most one per cycle
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == $past(free_cnt)) || (free_cnt == $past(free_cnt) + CNT_W'(1))
    || (free_cnt == $past(free_cnt) - CNT_W'(1)));

  // R3: rejection only follows an insert made while full
  a_r3_err_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> $past(full && ins_vld));

  // R3: a full queue accepts nothing, so it cannot go below zero
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full) |-> (free_cnt <= CNT_W'(1)));

  // R7: no pushes without an active walk
  a_r7_idle_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_busy |-> (push_vld == '0));

  // R8: a released entry always answers a request
  a_r8_rel_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> $past(rel_req));

  // R9: hit and miss are exclusive and only follow a request
  a_r9_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_vld && rel_miss));
  a_r9_miss_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rel_miss |-> $past(rel_req));

  // R5: lanes fill from lane 0 and run youngest first
  for (genvar k = 1; k < WALK; k++) begin : g_order
    a_r5_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld[k] |-> (push_vld[k-1] &&
        (push_seq[(k-1)*SEQ_W +: SEQ_W] > push_seq[k*SEQ_W +: SEQ_W])));
  end

endmodule

bind iq_seq_tracker iq_seq_tracker_chk #(
  .DEPTH (DEPTH),
  .SEQ_W (SEQ_W),
  .SRC_N (SRC_N),
  .WALK  (WALK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ins_vld  (ins_vld),
  .rel_req  (rel_req),
  .free_cnt (free_cnt),
  .full     (full),
  .ins_err  (ins_err),
  .sq_busy  (sq_busy),
  .push_vld (push_vld),
  .push_seq (push_seq),
  .rel_vld  (rel_vld),
  .rel_miss (rel_miss),
  .vld_q    (vld_q)
);

// File: tb/iq_seq_tracker_bench.sv
module iq_seq_tracker_bench;

  localparam int DEPTH = 8;
  localparam int SEQ_W = 8;
  localparam int SRC_N = 2;
  localparam int WALK  = 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                  clk;
  logic                  rst_n;
  logic                  ins_vld;
  logic [SEQ_W-1:0]      ins_seq;
  logic                  ins_hold;
  logic [SRC_N-1:0]      ins_src_rdy;
  logic                  iss_vld;
  logic [SEQ_W-1:0]      iss_seq;
  logic                  sq_req;
  logic [SEQ_W-1:0]      sq_seq;
  logic                  sq_stop;
  logic                  rel_req;
  logic [SEQ_W-1:0]      rel_seq;
  logic [CNT_W-1:0]      free_cnt;
  logic                  full;
  logic                  ins_err;
  logic                  sq_busy;
  logic [WALK-1:0]       push_vld;
  logic [WALK*SEQ_W-1:0] push_seq;
  logic [WALK*SRC_N-1:0] push_drop;
  logic                  rel_vld;
  logic [SEQ_W-1:0]      rel_out_seq;
  logic                  rel_miss;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  iq_seq_tracker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SRC_N(SRC_N), .WALK(WALK)) u_iq_seq_tracker (
    .clk(clk), .rst_n(rst_n),
    .ins_vld(ins_vld), .ins_seq(ins_seq), .ins_hold(ins_hold), .ins_src_rdy(ins_src_rdy),
    .iss_vld(iss_vld), .iss_seq(iss_seq),
    .sq_req(sq_req), .sq_seq(sq_seq), .sq_stop(sq_stop),
    .rel_req(rel_req), .rel_seq(rel_seq),
    .free_cnt(free_cnt), .full(full), .ins_err(ins_err),
    .sq_busy(sq_busy), .push_vld(push_vld), .push_seq(push_seq), .push_drop(push_drop),
    .rel_vld(rel_vld), .rel_out_seq(rel_out_seq), .rel_miss(rel_miss)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_insert(input int s, input bit hold, input logic [SRC_N-1:0] rdy);
    ins_vld = 1'b1; ins_seq = SEQ_W'(s); ins_hold = hold; ins_src_rdy = rdy;
    step();
    ins_vld = 1'b0;
  endtask

  task automatic do_issue(input int s);
    iss_vld = 1'b1; iss_seq = SEQ_W'(s);
    step();
    iss_vld = 1'b0;
  endtask

  task automatic do_release(input int s);
    rel_req = 1'b1; rel_seq = SEQ_W'(s);
    step();
    rel_req = 1'b0;
  endtask

  task automatic do_squash(input int s);
    sq_req = 1'b1; sq_seq = SEQ_W'(s);
    step();
    sq_req = 1'b0;
  endtask

  task automatic do_stop();
    sq_stop = 1'b1;
    step();
    sq_stop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 free_cnt", int'(free_cnt), DEPTH);
    check("R1 full", int'(full), 0);
    check("R1 sq_busy", int'(sq_busy), 0);
    check("R1 push_vld", int'(push_vld), 0);
    check("R1 ins_err", int'(ins_err), 0);
    check("R1 rel flags", int'({rel_vld, rel_miss}), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) begin
      do_insert(30 + i, 1'b0, '1);
      check("R2 count down", int'(free_cnt), DEPTH - 1 - i);
    end
    check("R3 full set", int'(full), 1);
    do_insert(30 + DEPTH, 1'b0, '1);
    check("R3 err pulse", int'(ins_err), 1);
    check("R3 count held", int'(free_cnt), 0);
    step();
    check("R3 err one cycle", int'(ins_err), 0);
    do_issue(30);
    check("R2 count up", int'(free_cnt), 1);
    check("R3 full clear", int'(full), 0);
    do_issue(30);
    check("R2 unknown issue", int'(free_cnt), 1);
    for (int i = 1; i < DEPTH; i++) begin
      do_issue(30 + i);
    end
    check("R2 drained", int'(free_cnt), DEPTH);
  endtask

  task automatic t_squash();
    do_insert(10, 1'b0, 2'b11);
    do_insert(11, 1'b1, 2'b00);
    do_insert(12, 1'b0, 2'b00);
    do_insert(13, 1'b0, 2'b01);
    do_insert(14, 1'b0, 2'b00);
    do_issue(12);
    check("R2 after issue", int'(free_cnt), DEPTH - 4);
    do_squash(10);
    check("R7 busy", int'(sq_busy), 1);
    check("R5 lanes cycle1", int'(push_vld), 2'b11);
    check("R5 lane0 youngest", int'(push_seq[SEQ_W-1:0]), 14);
    check("R4 lane1 seq", int'(push_seq[2*SEQ_W-1:SEQ_W]), 13);
    check("R6 lane0 drop", int'(push_drop[SRC_N-1:0]), 2'b11);
    check("R6 lane1 drop", int'(push_drop[2*SRC_N-1:SRC_N]), 2'b10);
    step();
    check("R5 lanes cycle2", int'(push_vld), 2'b01);
    check("R4 skips issued", int'(push_seq[SEQ_W-1:0]), 11);
    check("R6 held no drop", int'(push_drop[SRC_N-1:0]), 0);
    step();
    check("R4 stops at squash number", int'(push_vld), 0);
    check("R7 busy done", int'(sq_busy), 0);
    check("R10 count unchanged", int'(free_cnt), DEPTH - 4);
    do_stop();
    do_release(11);
    check("R9 squashed held miss", int'(rel_miss), 1);
    check("R9 no rel_vld", int'(rel_vld), 0);
    do_squash(9);
    check("R11 only new entry", int'(push_vld), 2'b01);
    check("R11 seq", int'(push_seq[SEQ_W-1:0]), 10);
    check("R6 ready sources", int'(push_drop[SRC_N-1:0]), 0);
    step();
    check("R11 walk ends", int'(sq_busy), 0);
    do_stop();
    do_issue(10); do_issue(11); do_issue(13); do_issue(14);
    check("R10 freed by issue", int'(free_cnt), DEPTH);
  endtask

  task automatic t_hold();
    do_insert(20, 1'b1, 2'b00);
    check("R8 not released", int'(rel_vld), 0);
    do_release(21);
    check("R9 unknown miss", int'(rel_miss), 1);
    do_release(20);
    check("R8 rel_vld", int'(rel_vld), 1);
    check("R8 rel seq", int'(rel_out_seq), 20);
    check("R9 no miss on hit", int'(rel_miss), 0);
    do_release(20);
    check("R9 repeat miss", int'(rel_miss), 1);
    check("R9 repeat no vld", int'(rel_vld), 0);
    do_issue(20);
    check("R2 held freed", int'(free_cnt), DEPTH);
  endtask

  task automatic t_zero_stop();
    do_insert(40, 1'b0, 2'b10);
    do_squash(0);
    check("R7 zero no busy", int'(sq_busy), 0);
    check("R7 zero no push", int'(push_vld), 0);
    sq_req = 1'b1; sq_seq = SEQ_W'(39); sq_stop = 1'b1;
    step();
    sq_req = 1'b0; sq_stop = 1'b0;
    check("R7 stop wins", int'(sq_busy), 0);
    do_squash(39);
    check("R7 active busy", int'(sq_busy), 1);
    check("R6 drop", int'(push_drop[SRC_N-1:0]), 2'b01);
    do_stop();
    check("R7 stop clears", int'(sq_busy), 0);
    do_issue(40);
    check("R2 final", int'(free_cnt), DEPTH);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ins_vld = 1'b0; ins_seq = '0; ins_hold = 1'b0; ins_src_rdy = '0;
    iss_vld = 1'b0; iss_seq = '0;
    sq_req = 1'b0; sq_seq = '0; sq_stop = 1'b0;
    rel_req = 1'b0; rel_seq = '0;
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_full();
    t_squash();
    t_hold();
    t_zero_stop();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule